// File: doc/BRIEF.md
# Multiplexed Envelope Attenuation Sequencer

This block steps the loudness envelope of 24 time-shared operator slots. Each slot owns a 10-bit attenuation value, where 0 is full volume and 0x3FF is silence, and one of four phases: attack, decay, sustain, release. One beat arrives per slot turn. Each beat carries the key bit now, the key bit from the last turn, a rate shift, a maximum-rate flag, a 5-bit sustain target and two waveform-shaping flags (step boost and level mirroring). The block reads the stored slot, computes the next attenuation and phase, writes them back and reports the result with a phase-restart flag.

Beats enter on a valid/ready port and results leave on a valid/ready port. An internal counter selects the slot. It advances once per accepted beat and wraps from 23 to 0. A result stays on the output until it is taken. While an untaken result is held, no new beat is accepted, so back-pressure on the output stalls the input directly. Deriving the rate shift from a global timer and adding a total-level offset are done by neighbouring logic.

Top module: `eg_adsr_core`

## Requirements
- R1: After reset every slot is in release (phase code 3) at level 0x3FF, `out_valid` is 0 and the first accepted beat works on slot 0.
- R2: Each accepted beat works on the slot the internal counter selects and reports it on `out_slot`. The counter goes 0,1,…,23,0.
- R3: A key-on event (key now 1, key before 0) sets the attack phase (code 0) and raises `out_phase_rst` for that beat only. No other beat raises it.
- R4: In attack, with the key held, a nonzero shift and no maximum rate, the level changes by the arithmetic value ((NOT level) << shift) >> 5, which moves it toward 0.
- R5: A key-on event with maximum rate sets the level to 0 at once. Maximum rate without a key-on event leaves an attack level unchanged.
- R6: An attack slot whose level is 0 moves to decay (code 1).
- R7: In decay, when level >> 5 equals the sustain target the phase becomes sustain (code 2) with no step. Otherwise the level rises by 1 << (shift-1) when the shift is nonzero and the envelope is not off. Sustain and release use the same step.
- R8: With boost enabled, the decay, sustain and release steps are four times larger.
- R9: The envelope is off when level AND 0x3F0 equals 0x3F0, or, with boost enabled, when level bit 9 is set. An off envelope outside attack, on a beat with no key-on event, goes to release at 0x3FF.
- R10: On a key-off event (key before 1, key now 0) with mirroring set, the level is first replaced by (512 − level) AND 0x3FF.
- R11: A beat with key now 0 and no key-on event ends in release (code 3).
- R12: `in_ready` is high when no result is held or `out_ready` is high. A held result keeps `out_slot`, `out_level`, `out_state` and `out_phase_rst` stable until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present |
| in_ready | output | 1 | Beat accepted this cycle when high with in_valid |
| in_key_now | input | 1 | Key bit for this turn |
| in_key_prev | input | 1 | Key bit from the slot's previous turn |
| in_shift | input | SHIFT_W (3) | Rate-derived step shift, 0 means no step |
| in_rate_max | input | 1 | Maximum rate flag |
| in_sus_lvl | input | 5 | Sustain target compared with level >> 5 |
| in_boost | input | 1 | Step boost and bit-9 off test |
| in_mirror | input | 1 | Level mirroring on key-off |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken this cycle when high with out_valid |
| out_slot | output | 5 | Slot the result belongs to |
| out_level | output | 10 | New attenuation |
| out_state | output | 2 | New phase: 0 attack, 1 decay, 2 sustain, 3 release |
| out_phase_rst | output | 1 | Phase restart flag |

## Verification
The hardest case to reach is the off threshold from below. A slot only reaches it by climbing through decay and sustain, one turn at a time, so the stimulus needs dozens of full 24-slot revolutions. Boosted steps give the fast early climb, but boost has to be turned off before the level reaches bit 9. If it stays on, the bit-9 off test ends the climb early. The bench parks every other slot on idle beats and keeps stepping one slot until its level crosses 0x3E0, 0x3E8 and 0x3F0. It then checks that the next beat forces release at 0x3FF.

// File: rtl/egadsr_pkg.sv
package egadsr_pkg;
  localparam int LVL_W = 10;
  localparam int SL_W  = 5;
  localparam int ST_W  = 2;

  typedef enum logic [ST_W-1:0] {
    PH_ATTACK  = 2'd0,
    PH_DECAY   = 2'd1,
    PH_SUSTAIN = 2'd2,
    PH_RELEASE = 2'd3
  } eg_phase_e;

  localparam logic [LVL_W-1:0] LVL_SILENT = {LVL_W{1'b1}};
  localparam logic [LVL_W-1:0] LVL_OFFMSK = {{(LVL_W-4){1'b1}}, 4'b0000};
  localparam logic [LVL_W-1:0] LVL_HALF   = {1'b1, {(LVL_W-1){1'b0}}};
endpackage

// File: rtl/eg_step.sv
module eg_step
  import egadsr_pkg::*;
#(
  parameter int SHIFT_W = 3
) (
  input  logic [LVL_W-1:0]   cur_lvl,
  input  eg_phase_e          cur_ph,
  input  logic               key_now,
  input  logic               key_prev,
  input  logic [SHIFT_W-1:0] shift,
  input  logic               rate_max,
  input  logic [SL_W-1:0]    sus_lvl,
  input  logic               boost,
  input  logic               mirror,
  output logic [LVL_W-1:0]   nxt_lvl,
  output eg_phase_e          nxt_ph,
  output logic               phase_rst
);
  localparam int AW = LVL_W + (1 << SHIFT_W) + 2;

  logic                    kon_ev, koff_ev, is_off;
  logic [LVL_W-1:0]        mir_lvl, lvl, base_lvl;
  logic signed [AW-1:0]    lvl_s, att_step, dec_step, step;
  logic [SHIFT_W:0]        sh_m1;

  assign mir_lvl = LVL_HALF - cur_lvl;

  always_comb begin
    kon_ev  = key_now & ~key_prev;
    koff_ev = key_prev & ~key_now;
    lvl     = (koff_ev && mirror) ? mir_lvl : cur_lvl;
    is_off  = boost ? lvl[LVL_W-1] : ((lvl & LVL_OFFMSK) == LVL_OFFMSK);

    lvl_s    = signed'(AW'(lvl));
    att_step = ((~lvl_s) <<< shift) >>> 5;
    sh_m1    = {1'b0, shift} - 1'b1;
    dec_step = signed'(AW'(1) << sh_m1);
    if (boost) dec_step = dec_step <<< 2;

    step     = '0;
    base_lvl = lvl;
    nxt_ph   = cur_ph;

    if (kon_ev) begin
      nxt_ph = PH_ATTACK;
      if (rate_max) begin
        base_lvl = '0;
      end else if (cur_ph == PH_ATTACK && lvl != '0 && shift != '0 && key_now) begin
        step = att_step;
      end
    end else begin
      unique case (cur_ph)
        PH_ATTACK: begin
          if (lvl == '0) nxt_ph = PH_DECAY;
          else if (shift != '0 && !rate_max && key_now) step = att_step;
        end
        PH_DECAY: begin
          if (lvl[LVL_W-1 -: SL_W] == sus_lvl) nxt_ph = PH_SUSTAIN;
          else if (!is_off && shift != '0) step = dec_step;
        end
        default: begin
          if (!is_off && shift != '0) step = dec_step;
        end
      endcase
      if (!key_now) nxt_ph = PH_RELEASE;
    end

    if (!kon_ev && cur_ph != PH_ATTACK && is_off) begin
      nxt_ph   = PH_RELEASE;
      base_lvl = LVL_SILENT;
    end

    nxt_lvl   = LVL_W'(signed'(AW'(base_lvl)) + step);
    phase_rst = kon_ev;
  end
endmodule

// File: rtl/eg_slot_store.sv
module eg_slot_store
  import egadsr_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LVL_W-1:0]  wr_lvl,
  input  eg_phase_e         wr_ph,
  output logic [SLOT_W-1:0] cur_slot,
  output logic [LVL_W-1:0]  rd_lvl,
  output eg_phase_e         rd_ph
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  logic [LVL_W-1:0] lvl_mem [NUM_SLOTS];
  eg_phase_e        ph_mem  [NUM_SLOTS];
  logic [SLOT_W-1:0] slot_q;

  assign cur_slot = slot_q;
  assign rd_lvl   = lvl_mem[slot_q];
  assign rd_ph    = ph_mem[slot_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
    end else if (we) begin
      slot_q <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_mem[g] <= LVL_SILENT;
        ph_mem[g]  <= PH_RELEASE;
      end else if (we && slot_q == SLOT_W'(g)) begin
        lvl_mem[g] <= wr_lvl;
        ph_mem[g]  <= wr_ph;
      end
    end
  end
endmodule

// File: rtl/eg_out_stage.sv
module eg_out_stage
  import egadsr_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [SLOT_W-1:0] nxt_slot,
  input  logic [LVL_W-1:0]  nxt_lvl,
  input  eg_phase_e         nxt_ph,
  input  logic              nxt_prst,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [SLOT_W-1:0] out_slot,
  output logic [LVL_W-1:0]  out_level,
  output logic [ST_W-1:0]   out_state,
  output logic              out_phase_rst
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_slot      <= '0;
      out_level     <= LVL_SILENT;
      out_state     <= PH_RELEASE;
      out_phase_rst <= 1'b0;
    end else if (accept) begin
      out_valid     <= 1'b1;
      out_slot      <= nxt_slot;
      out_level     <= nxt_lvl;
      out_state     <= nxt_ph;
      out_phase_rst <= nxt_prst;
    end else if (out_ready) begin
      out_valid     <= 1'b0;
    end
  end
endmodule

// File: rtl/eg_adsr_core.sv
module eg_adsr_core
  import egadsr_pkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int SHIFT_W   = 3,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_key_now,
  input  logic               in_key_prev,
  input  logic [SHIFT_W-1:0] in_shift,
  input  logic               in_rate_max,
  input  logic [SL_W-1:0]    in_sus_lvl,
  input  logic               in_boost,
  input  logic               in_mirror,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SLOT_W-1:0]  out_slot,
  output logic [LVL_W-1:0]   out_level,
  output logic [ST_W-1:0]    out_state,
  output logic               out_phase_rst
);
  logic              accept, nxt_prst;
  logic [SLOT_W-1:0] cur_slot;
  logic [LVL_W-1:0]  rd_lvl, nxt_lvl;
  eg_phase_e         rd_ph, nxt_ph;

  assign accept = in_valid & in_ready;

  eg_slot_store #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) store_i (
    .clk(clk), .rst_n(rst_n), .we(accept),
    .wr_lvl(nxt_lvl), .wr_ph(nxt_ph),
    .cur_slot(cur_slot), .rd_lvl(rd_lvl), .rd_ph(rd_ph)
  );

  eg_step #(.SHIFT_W(SHIFT_W)) step_i (
    .cur_lvl(rd_lvl), .cur_ph(rd_ph),
    .key_now(in_key_now), .key_prev(in_key_prev),
    .shift(in_shift), .rate_max(in_rate_max), .sus_lvl(in_sus_lvl),
    .boost(in_boost), .mirror(in_mirror),
    .nxt_lvl(nxt_lvl), .nxt_ph(nxt_ph), .phase_rst(nxt_prst)
  );

  eg_out_stage #(.SLOT_W(SLOT_W)) out_i (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .nxt_slot(cur_slot), .nxt_lvl(nxt_lvl), .nxt_ph(nxt_ph), .nxt_prst(nxt_prst),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_slot(out_slot), .out_level(out_level), .out_state(out_state),
    .out_phase_rst(out_phase_rst)
  );
endmodule

// File: rtl/eg_adsr_chk.sv
module eg_adsr_chk #(
  parameter int NUM_SLOTS = 24,
  parameter int SLOT_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_key_now,
  input logic              in_key_prev,
  input logic              in_rate_max,
  input logic              out_valid,
  input logic              out_ready,
  input logic [SLOT_W-1:0] out_slot,
  input logic [9:0]        out_level,
  input logic [1:0]        out_state,
  input logic              out_phase_rst,
  input logic [SLOT_W-1:0] cur_slot
);
  logic acc;
  assign acc = in_valid & in_ready;

  assert_stall_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot) && $stable(out_level)
                                   && $stable(out_state) && $stable(out_phase_rst)));

  assert_accept_shows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_slot_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_slot == SLOT_W'(NUM_SLOTS - 1)) |=> (cur_slot == '0));

  assert_rst_pulse_attack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_phase_rst) |-> (out_state == 2'd0));

  assert_instant_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_key_now && !in_key_prev && in_rate_max) |=> (out_level == '0));

  assert_keyup_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_key_now) |=> (out_state == 2'd3));
endmodule

bind eg_adsr_core eg_adsr_chk #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_key_now(in_key_now), .in_key_prev(in_key_prev), .in_rate_max(in_rate_max),
  .out_valid(out_valid), .out_ready(out_ready), .out_slot(out_slot),
  .out_level(out_level), .out_state(out_state), .out_phase_rst(out_phase_rst),
  .cur_slot(cur_slot)
);

// File: tb/eg_adsr_core_tb.sv
module eg_adsr_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 60000;

  typedef struct packed {
    logic       kn;
    logic       kp;
    logic [2:0] sh;
    logic       rm;
    logic [4:0] sl;
    logic       bo;
    logic       mi;
    logic [9:0] lv;
    logic [1:0] st;
    logic       pr;
  } vec_t;

  // applied to slots 0..5 straight after reset (each slot at release, 0x3FF)
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 3'd1, 1'b0, 5'd0, 1'b0, 1'b0, 10'h3FF, 2'd0, 1'b1}, // R3 key-on
    '{1'b1, 1'b0, 3'd0, 1'b1, 5'd0, 1'b0, 1'b0, 10'h000, 2'd0, 1'b1}, // R5 instant
    '{1'b0, 1'b0, 3'd2, 1'b0, 5'd0, 1'b0, 1'b0, 10'h3FF, 2'd3, 1'b0}, // R11 idle
    '{1'b1, 1'b1, 3'd1, 1'b0, 5'd0, 1'b0, 1'b0, 10'h3FF, 2'd3, 1'b0}, // R9 off held
    '{1'b0, 1'b1, 3'd1, 1'b0, 5'd0, 1'b0, 1'b1, 10'h202, 2'd3, 1'b0}, // R10 mirror
    '{1'b0, 1'b1, 3'd2, 1'b0, 5'd0, 1'b1, 1'b1, 10'h3FF, 2'd3, 1'b0}  // R9 bit9 off
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_key_now = 1'b0, in_key_prev = 1'b0;
  logic [2:0] in_shift = '0;
  logic in_rate_max = 1'b0, in_boost = 1'b0, in_mirror = 1'b0;
  logic [4:0] in_sus_lvl = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_phase_rst;
  logic [4:0] out_slot;
  logic [9:0] out_level;
  logic [1:0] out_state;

  int total = 0, bad = 0, cyc = 0, nslot = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  eg_adsr_core dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_key_now(in_key_now), .in_key_prev(in_key_prev), .in_shift(in_shift),
    .in_rate_max(in_rate_max), .in_sus_lvl(in_sus_lvl), .in_boost(in_boost),
    .in_mirror(in_mirror), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot(out_slot), .out_level(out_level), .out_state(out_state),
    .out_phase_rst(out_phase_rst)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic beat(input logic kn, input logic kp, input logic [2:0] sh,
                      input logic rm, input logic [4:0] sl, input logic bo, input logic mi);
    @(negedge clk);
    in_valid = 1'b1; in_key_now = kn; in_key_prev = kp; in_shift = sh;
    in_rate_max = rm; in_sus_lvl = sl; in_boost = bo; in_mirror = mi;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    nslot = (nslot + 1) % 24;
  endtask

  task automatic go_to(input int target);
    while (nslot != target) beat(1'b0, 1'b0, 3'd0, 1'b0, 5'd0, 1'b0, 1'b0);
  endtask

  task automatic on6(input logic kn, input logic kp, input logic [2:0] sh,
                     input logic rm, input logic [4:0] sl, input logic bo,
                     input int elv, input int est, input string tag);
    go_to(6);
    beat(kn, kp, sh, rm, sl, bo, 1'b0);
    chk({tag, " level"}, out_level, elv);
    chk({tag, " phase"}, out_state, est);
  endtask

  initial begin
    #(CLK_PERIOD*2 + 2);
    // R1: reset state at the ports
    chk("R1 out_valid after reset", out_valid, 0);
    chk("R1 in_ready after reset", in_ready, 1);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      beat(VECS[i].kn, VECS[i].kp, VECS[i].sh, VECS[i].rm, VECS[i].sl, VECS[i].bo, VECS[i].mi);
      chk($sformatf("R2 vec%0d slot", i), out_slot, i);
      chk($sformatf("R4/R9/R10 vec%0d level", i), out_level, VECS[i].lv);
      chk($sformatf("R11 vec%0d phase", i), out_state, VECS[i].st);
      chk($sformatf("R3 vec%0d phase restart", i), out_phase_rst, VECS[i].pr);
      chk($sformatf("R12 vec%0d valid", i), out_valid, 1);
    end

    // slot 6 walks attack, decay, sustain and release
    go_to(6);
    beat(1'b1, 1'b0, 3'd1, 1'b0, 5'd0, 1'b0, 1'b0);
    chk("R3 key-on restart", out_phase_rst, 1);
    chk("R3 key-on phase", out_state, 0);
    on6(1'b1, 1'b1, 3'd1, 1'b0, 5'd0, 1'b0, 10'h3BF, 0, "R4 attack shift1");
    chk("R3 no restart when held", out_phase_rst, 0);
    on6(1'b1, 1'b1, 3'd2, 1'b0, 5'd0, 1'b0, 10'h347, 0, "R4 attack shift2");
    on6(1'b1, 1'b1, 3'd2, 1'b1, 5'd0, 1'b0, 10'h347, 0, "R5 max rate held key");
    on6(1'b1, 1'b0, 3'd0, 1'b1, 5'd0, 1'b0, 10'h000, 0, "R5 max rate key-on");
    on6(1'b1, 1'b1, 3'd0, 1'b0, 5'd0, 1'b0, 10'h000, 1, "R6 attack to decay");
    on6(1'b1, 1'b1, 3'd3, 1'b0, 5'd1, 1'b0, 10'h004, 1, "R7 decay step");
    on6(1'b1, 1'b1, 3'd3, 1'b0, 5'd1, 1'b1, 10'h014, 1, "R8 boosted decay");
    on6(1'b1, 1'b1, 3'd3, 1'b0, 5'd0, 1'b0, 10'h014, 2, "R7 decay to sustain");
    on6(1'b1, 1'b1, 3'd1, 1'b0, 5'd0, 1'b0, 10'h015, 2, "R7 sustain step");
    on6(1'b0, 1'b1, 3'd1, 1'b0, 5'd0, 1'b0, 10'h016, 3, "R11 key-off release");
    on6(1'b0, 1'b0, 3'd0, 1'b0, 5'd0, 1'b0, 10'h016, 3, "R11 release hold");

    // slot 7 climbs to the off threshold (R9)
    go_to(7);
    beat(1'b1, 1'b0, 3'd0, 1'b1, 5'd0, 1'b0, 1'b0);
    go_to(7);
    beat(1'b1, 1'b1, 3'd0, 1'b0, 5'd31, 1'b0, 1'b0);
    for (int k = 0; k < 15; k++) begin
      go_to(7); beat(1'b1, 1'b1, 3'd4, 1'b0, 5'd31, 1'b1, 1'b0);
    end
    chk("R8 boosted climb level", out_level, 480);
    for (int k = 0; k < 64; k++) begin
      go_to(7); beat(1'b1, 1'b1, 3'd4, 1'b0, 5'd31, 1'b0, 1'b0);
    end
    chk("R7 climb level", out_level, 992);
    chk("R7 climb phase", out_state, 1);
    go_to(7); beat(1'b1, 1'b1, 3'd4, 1'b0, 5'd31, 1'b0, 1'b0);
    chk("R7 reach sustain", out_state, 2);
    go_to(7); beat(1'b1, 1'b1, 3'd4, 1'b0, 5'd31, 1'b0, 1'b0);
    chk("R9 below threshold", out_level, 1000);
    go_to(7); beat(1'b1, 1'b1, 3'd4, 1'b0, 5'd31, 1'b0, 1'b0);
    chk("R9 at threshold", out_level, 1008);
    go_to(7); beat(1'b1, 1'b1, 3'd4, 1'b0, 5'd31, 1'b0, 1'b0);
    chk("R9 off forces silent", out_level, 10'h3FF);
    chk("R9 off forces release", out_state, 3);

    // R12 back-pressure
    beat(1'b1, 1'b0, 3'd0, 1'b1, 5'd0, 1'b0, 1'b0);
    begin
      automatic int held_slot = out_slot;
      automatic int held_lvl = out_level;
      out_ready = 1'b0;
      in_valid = 1'b1; in_key_now = 1'b0; in_key_prev = 1'b0; in_shift = 3'd0; in_rate_max = 1'b0;
      #1;
      chk("R12 in_ready low while held", in_ready, 0);
      @(posedge clk); #1;
      chk("R12 held valid", out_valid, 1);
      chk("R12 held slot", out_slot, held_slot);
      chk("R12 held level", out_level, held_lvl);
      out_ready = 1'b1;
      #1;
      chk("R12 in_ready when taken", in_ready, 1);
      @(posedge clk); #1;
      in_valid = 1'b0;
      chk("R12 next slot after stall", out_slot, (held_slot + 1) % 24);
      nslot = (held_slot + 2) % 24;
    end

    // R1: reset clears slot 6 (was release at 0x16)
    @(negedge clk);
    rst_n = 1'b0;
    #(CLK_PERIOD*2);
    rst_n = 1'b1;
    nslot = 0;
    beat(1'b1, 1'b1, 3'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    chk("R1 first slot after reset", out_slot, 0);
    go_to(6);
    beat(1'b1, 1'b1, 3'd0, 1'b0, 5'd0, 1'b0, 1'b0);
    chk("R1 slot level after reset", out_level, 10'h3FF);
    chk("R1 slot phase after reset", out_state, 3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule